// File: doc/BRIEF.md
# Streaming Harris Corner Scorer

This block turns a raster-ordered greyscale pixel stream into a signed cornerness score per pixel position. For each pixel it forms a centred-difference gradient in both directions, multiplies the gradients into the three structure-tensor products, and adds each product over a uniform 3×3 window. From those three window sums it computes the determinant of the 2×2 structure tensor minus k times its squared trace, all in integer fixed point. A large positive score marks a corner, a large negative score marks an edge, and a value near zero marks a flat area.

Pixels enter on a valid strobe with an end-of-line flag. The frame size is fixed by parameters, and the scores leave on a matching valid/end-of-line stream with a constant delay. The block never stalls its input. The response uses the five-by-five pixel neighbourhood that ends at the newest pixel, so the score emitted for input position (x, y) describes the pixel centred two columns to the left and two rows above. Positions where that neighbourhood does not lie inside the frame emit zero. The weighting constant k is a held register, and a one-cycle load strobe replaces its value.

Top module: `harris_scorer`

## Requirements
- R1: For a pixel at column c and row r, the horizontal gradient is p(c+1,r) − p(c−1,r) and the vertical gradient is p(c,r+1) − p(c,r−1). The three window sums add Gx², Gx·Gy and Gy² over the 3×3 gradient positions around the centre, with equal weights.
- R2: With sums A = ΣGx², B = ΣGy² and C = ΣGx·Gy, the score is (A·B − C²) − floor(k·(A+B)² / 256). k is an unsigned 8-bit value read as k/256, and the product is formed at full width before the 8-bit right shift.
- R3: The k register resets to 12 (about 0.047). It takes k_value when k_load is high at a rising edge, and it keeps its value otherwise. k is changed only while no pixel is in flight.
- R4: Exactly one score is produced for each accepted pixel, in input order. The score at output position (x, y) is the response centred at pixel (x−2, y−2).
- R5: The score at output position (x, y) is zero when x < 4 or y < 4.
- R6: pix_eol must be high on the pixel in column FRAME_W−1 and only there. score_eol is high exactly with the score of output column FRAME_W−1.
- R7: After reset, score_valid and score_eol are low. A pixel sampled at rising edge n gives score_valid high when sampled at rising edge n+7 (default configuration), and there is no other output activity.
- R8: Idle cycles between pixels do not change any score value; only positions in the frame matter.
- R9: Row counting wraps after FRAME_H rows, so frames sent back to back are each scored as a fresh frame, including the zero border.
- R10: A uniform frame scores zero everywhere. A straight vertical step edge gives a negative score at the edge. A bright quadrant gives a positive score at its corner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Pixel strobe |
| pix_data | input | PIX_W | Unsigned greyscale intensity |
| pix_eol | input | 1 | High on the last pixel of a row |
| k_load | input | 1 | Load strobe for the k register |
| k_value | input | K_W | New k, unsigned, scaled by 2^-K_W |
| score_valid | output | 1 | Score strobe |
| score | output | SCORE_W | Signed cornerness score |
| score_eol | output | 1 | High with the last score of a row |

## Verification
The embedded assertions check several rules on every cycle. The output strobe must follow the input strobe by exactly the pipeline delay. Every score in the border band must be zero, and the output end-of-line flag must coincide with the final column. The input flag must sit on the final column, and the trace fed to the response stage must be non-negative. The exact score values can only be shown by the bench's scenarios. These include the gradient and window arithmetic on random and full-swing frames, the k scaling (reset default, maximum and a loaded value), independence from idle gaps, back-to-back frame wrap, and the sign of the response on flat, edge and corner images.

// File: rtl/harris_pkg.sv
package harris_pkg;
   // Reach of one centred difference plus reach of the summing window.
   localparam int HS_REACH  = 2;
   // Output positions closer than this to the left/top edge carry no score.
   localparam int HS_BORDER = 2 * HS_REACH;

   typedef struct packed {
      logic inner;   // window lies fully inside the frame
      logic eol;     // end-of-line marker travelling with the token
   } hs_tag_t;
endpackage

// File: rtl/hs_linebuf.sv
module hs_linebuf #(
   parameter  int DEPTH = 16,
   parameter  int DW    = 8,
   parameter  int ROWS  = 2,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic                     clk,
   input  logic                     en,
   input  logic [AW-1:0]            col,
   input  logic [DW-1:0]            din,
   output logic [ROWS-1:0][DW-1:0]  taps
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("hs_linebuf: DEPTH must be at least 2");
   end
   if (ROWS < 1) begin : g_bad_rows
      $error("hs_linebuf: ROWS must be at least 1");
   end

   logic [DW-1:0] mem [ROWS][DEPTH];

   // taps[0] is one row back, taps[ROWS-1] is ROWS rows back
   for (genvar r = 0; r < ROWS; r++) begin : g_tap
      assign taps[r] = mem[r][col];
   end

   always_ff @(posedge clk) begin
      if (en) begin
         mem[0][col] <= din;
         for (int r = 1; r < ROWS; r++) begin
            mem[r][col] <= mem[r-1][col];
         end
      end
   end
endmodule

// File: rtl/hs_gradient.sv
module hs_gradient #(
   parameter  int FRAME_W = 16,
   parameter  int PIX_W   = 8,
   localparam int AW      = (FRAME_W > 1) ? $clog2(FRAME_W) : 1,
   localparam int GW      = PIX_W + 1,
   localparam int PRW     = 2 * GW
) (
   input  logic                  clk,
   input  logic                  pix_en,
   input  logic [AW-1:0]         col,
   input  logic [PIX_W-1:0]      pix,
   input  logic                  grad_en,
   input  logic                  prod_en,
   output logic signed [PRW-1:0] pxx,
   output logic signed [PRW-1:0] pxy,
   output logic signed [PRW-1:0] pyy
);
   logic [1:0][PIX_W-1:0] taps;
   logic [PIX_W-1:0]      win [3][3];   // [row: 0 oldest][column: 0 oldest]
   logic [PIX_W-1:0]      newcol [3];
   logic signed [GW-1:0]  gx, gy;

   hs_linebuf #(.DEPTH(FRAME_W), .DW(PIX_W), .ROWS(2)) u_rows (
      .clk (clk),
      .en  (pix_en),
      .col (col),
      .din (pix),
      .taps(taps)
   );

   always_comb begin
      newcol[0] = taps[1];
      newcol[1] = taps[0];
      newcol[2] = pix;
   end

   always_ff @(posedge clk) begin
      if (pix_en) begin
         for (int r = 0; r < 3; r++) begin
            win[r][0] <= win[r][1];
            win[r][1] <= win[r][2];
            win[r][2] <= newcol[r];
         end
      end
   end

   // centre of the window is win[1][1]
   always_ff @(posedge clk) begin
      if (grad_en) begin
         gx <= $signed({1'b0, win[1][2]}) - $signed({1'b0, win[1][0]});
         gy <= $signed({1'b0, win[2][1]}) - $signed({1'b0, win[0][1]});
      end
   end

   always_ff @(posedge clk) begin
      if (prod_en) begin
         pxx <= PRW'(gx) * PRW'(gx);
         pxy <= PRW'(gx) * PRW'(gy);
         pyy <= PRW'(gy) * PRW'(gy);
      end
   end
endmodule

// File: rtl/hs_winsum.sv
module hs_winsum #(
   parameter  int FRAME_W = 16,
   parameter  int IN_W    = 18,
   localparam int AW      = (FRAME_W > 1) ? $clog2(FRAME_W) : 1,
   localparam int SUM_W   = IN_W + 4
) (
   input  logic                    clk,
   input  logic                    col_en,
   input  logic [AW-1:0]           col,
   input  logic signed [IN_W-1:0]  din,
   input  logic                    sum_en,
   output logic signed [SUM_W-1:0] sum
);
   logic [1:0][IN_W-1:0]    taps;
   logic signed [SUM_W-1:0] cs_now, cs0, cs1, cs2;

   hs_linebuf #(.DEPTH(FRAME_W), .DW(IN_W), .ROWS(2)) u_rows (
      .clk (clk),
      .en  (col_en),
      .col (col),
      .din (din),
      .taps(taps)
   );

   // vertical three-row sum of the current column
   assign cs_now = SUM_W'(din)
                 + SUM_W'($signed(taps[0]))
                 + SUM_W'($signed(taps[1]));

   always_ff @(posedge clk) begin
      if (col_en) begin
         cs0 <= cs_now;
         cs1 <= cs0;
         cs2 <= cs1;
      end
   end

   always_ff @(posedge clk) begin
      if (sum_en) begin
         sum <= cs0 + cs1 + cs2;
      end
   end
endmodule

// File: rtl/hs_response.sv
module hs_response #(
   parameter  int SUM_W   = 22,
   parameter  int K_W     = 8,
   parameter  int SCORE_W = 48,
   parameter  bit SPLIT   = 1'b1,
   localparam int TR_W    = SUM_W + 1,
   localparam int DET_W   = 2 * SUM_W + 1,
   localparam int FULL_W  = 2 * TR_W + K_W + 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      a_en,
   input  logic                      a_inner,
   input  logic                      b_en,
   input  logic                      b_inner,
   input  logic signed [SUM_W-1:0]   sxx,
   input  logic signed [SUM_W-1:0]   sxy,
   input  logic signed [SUM_W-1:0]   syy,
   input  logic [K_W-1:0]            k,
   output logic signed [SCORE_W-1:0] score
);
   logic signed [DET_W-1:0] det_c;
   logic signed [TR_W-1:0]  tr_c;

   assign det_c = DET_W'(sxx) * DET_W'(syy) - DET_W'(sxy) * DET_W'(sxy);
   assign tr_c  = TR_W'(sxx) + TR_W'(syy);

   function automatic logic signed [SCORE_W-1:0] finish_score(
      input logic signed [DET_W-1:0] det,
      input logic signed [TR_W-1:0]  tr,
      input logic [K_W-1:0]          kq,
      input logic                    inner
   );
      logic signed [FULL_W-1:0] tr_w, k_w, kt;
      tr_w = FULL_W'(tr);
      k_w  = FULL_W'({1'b0, kq});
      kt   = (tr_w * tr_w * k_w) >>> K_W;
      return inner ? (SCORE_W'(det) - SCORE_W'(kt)) : '0;
   endfunction

   if (SPLIT) begin : g_split
      logic signed [DET_W-1:0] det_q;
      logic signed [TR_W-1:0]  tr_q;
      always_ff @(posedge clk) begin
         if (a_en) begin
            det_q <= det_c;
            tr_q  <= tr_c;
         end
      end
      always_ff @(posedge clk) begin
         if (b_en) score <= finish_score(det_q, tr_q, k, b_inner);
      end
   end else begin : g_single
      always_ff @(posedge clk) begin
         if (b_en) score <= finish_score(det_c, tr_c, k, b_inner);
      end
   end

   AST_TRACE_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
      (a_en && a_inner) |-> (sxx >= 0 && syy >= 0))
      else $error("squared-gradient sums went negative"); // R1
endmodule

// File: rtl/harris_scorer.sv
module harris_scorer
   import harris_pkg::*;
#(
   parameter  int FRAME_W = 16,
   parameter  int FRAME_H = 12,
   parameter  int PIX_W   = 8,
   parameter  int K_W     = 8,
   parameter  int K_RESET = 12,
   parameter  int SCORE_W = 48,
   parameter  bit SPLIT   = 1'b1,
   localparam int AW      = $clog2(FRAME_W),
   localparam int RW      = $clog2(FRAME_H),
   localparam int GW      = PIX_W + 1,
   localparam int PRW     = 2 * GW,
   localparam int SUM_W   = PRW + 4,
   localparam int LAT     = 6 + int'(SPLIT)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      pix_valid,
   input  logic [PIX_W-1:0]          pix_data,
   input  logic                      pix_eol,
   input  logic                      k_load,
   input  logic [K_W-1:0]            k_value,
   output logic                      score_valid,
   output logic signed [SCORE_W-1:0] score,
   output logic                      score_eol
);
   if (FRAME_W <= HS_BORDER || FRAME_H <= HS_BORDER) begin : g_bad_frame
      $error("harris_scorer: frame must exceed the border band");
   end
   if (SCORE_W < 2 * (SUM_W + 1) + 1) begin : g_bad_score
      $error("harris_scorer: SCORE_W too narrow for the response");
   end
   if (K_W < 1 || K_RESET >= (1 << K_W)) begin : g_bad_k
      $error("harris_scorer: k width or reset value out of range");
   end

   logic [AW-1:0]  x_q;
   logic [RW-1:0]  y_q;
   logic [K_W-1:0] k_q;
   logic [LAT:1]   v_q;
   hs_tag_t        tag_q [1:LAT];
   logic [AW-1:0]  col_q [1:3];
   logic           inner_in;

   // input position counters
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_q <= '0;
         y_q <= '0;
      end else if (pix_valid) begin
         if (x_q == AW'(FRAME_W - 1)) begin
            x_q <= '0;
            y_q <= (y_q == RW'(FRAME_H - 1)) ? '0 : y_q + 1'b1;
         end else begin
            x_q <= x_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      k_q <= K_W'(K_RESET);
      else if (k_load) k_q <= k_value;
   end

   assign inner_in = (x_q >= AW'(HS_BORDER)) && (y_q >= RW'(HS_BORDER));

   // token strobes travel without stalls; tags and columns ride along
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= '0;
      else        v_q <= {v_q[LAT-1:1], pix_valid};
   end

   always_ff @(posedge clk) begin
      tag_q[1] <= '{inner: inner_in, eol: pix_eol};
      for (int i = 2; i <= LAT; i++) tag_q[i] <= tag_q[i-1];
      col_q[1] <= x_q;
      for (int i = 2; i <= 3; i++) col_q[i] <= col_q[i-1];
   end

   logic signed [PRW-1:0]   prod [3];
   logic signed [SUM_W-1:0] wsum [3];

   hs_gradient #(.FRAME_W(FRAME_W), .PIX_W(PIX_W)) u_grad (
      .clk    (clk),
      .pix_en (pix_valid),
      .col    (x_q),
      .pix    (pix_data),
      .grad_en(v_q[1]),
      .prod_en(v_q[2]),
      .pxx    (prod[0]),
      .pxy    (prod[1]),
      .pyy    (prod[2])
   );

   for (genvar p = 0; p < 3; p++) begin : g_sum
      hs_winsum #(.FRAME_W(FRAME_W), .IN_W(PRW)) u_sum (
         .clk   (clk),
         .col_en(v_q[3]),
         .col   (col_q[3]),
         .din   (prod[p]),
         .sum_en(v_q[4]),
         .sum   (wsum[p])
      );
   end

   hs_response #(.SUM_W(SUM_W), .K_W(K_W), .SCORE_W(SCORE_W), .SPLIT(SPLIT)) u_resp (
      .clk    (clk),
      .rst_n  (rst_n),
      .a_en   (v_q[5]),
      .a_inner(tag_q[5].inner),
      .b_en   (v_q[LAT-1]),
      .b_inner(tag_q[LAT-1].inner),
      .sxx    (wsum[0]),
      .sxy    (wsum[1]),
      .syy    (wsum[2]),
      .k      (k_q),
      .score  (score)
   );

   assign score_valid = v_q[LAT];
   assign score_eol   = tag_q[LAT].eol & v_q[LAT];

   // checker state: cycles since reset and output position
   logic [3:0]    since_q;
   logic [AW-1:0] ox_q;
   logic [RW-1:0] oy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_q <= '0;
         ox_q    <= '0;
         oy_q    <= '0;
      end else begin
         if (since_q != 4'(LAT)) since_q <= since_q + 1'b1;
         if (score_valid) begin
            if (ox_q == AW'(FRAME_W - 1)) begin
               ox_q <= '0;
               oy_q <= (oy_q == RW'(FRAME_H - 1)) ? '0 : oy_q + 1'b1;
            end else begin
               ox_q <= ox_q + 1'b1;
            end
         end
      end
   end

   AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (since_q == 4'(LAT)) |-> (score_valid == $past(pix_valid, LAT)))
      else $error("output strobe not aligned to input strobe"); // R7

   AST_BORDER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (score_valid && (ox_q < AW'(HS_BORDER) || oy_q < RW'(HS_BORDER))) |-> (score == '0))
      else $error("nonzero score in border band"); // R5

   AST_OUT_EOL: assert property (@(posedge clk) disable iff (!rst_n)
      score_valid |-> (score_eol == (ox_q == AW'(FRAME_W - 1))))
      else $error("output end-of-line misplaced"); // R6

   AST_IN_EOL: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |-> (pix_eol == (x_q == AW'(FRAME_W - 1))))
      else $error("input end-of-line misplaced"); // R6
endmodule

// File: tb/harris_scorer_tb.sv
`timescale 1ns/1ps
module harris_scorer_tb;
   localparam int FW = 16;
   localparam int FH = 12;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               pix_valid = 1'b0;
   logic [7:0]         pix_data = '0;
   logic               pix_eol = 1'b0;
   logic               k_load = 1'b0;
   logic [7:0]         k_value = '0;
   logic               score_valid;
   logic signed [47:0] score;
   logic               score_eol;

   harris_scorer #(.FRAME_W(FW), .FRAME_H(FH)) u_dut (
      .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
      .pix_eol(pix_eol), .k_load(k_load), .k_value(k_value),
      .score_valid(score_valid), .score(score), .score_eol(score_eol)
   );

   always #2.5 clk = ~clk;   // 200 MHz

   typedef struct packed {
      logic signed [63:0] sc;
      logic               eol;
      logic [7:0]         rq;
   } exp_t;

   exp_t   q [$];
   int     img [FH][FW];
   longint out_img [FH][FW];
   int     checks = 0, errors = 0;
   int     kcur = 12;
   longint cyc = 0, in_cyc = -1, out_cyc = -1;
   int     n_in = 0, n_out = 0, ox = 0, oy = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input int rq, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL R%0d: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   // reference response, straight from the requirement formulas (R1, R2, R5)
   function automatic longint model(input int x, input int y, input int kk);
      longint a = 0, b = 0, c = 0, det, tr, gx, gy;
      if (x < 4 || y < 4) return 0;
      for (int gr = y - 3; gr <= y - 1; gr++) begin
         for (int gc = x - 3; gc <= x - 1; gc++) begin
            gx = img[gr][gc+1] - img[gr][gc-1];
            gy = img[gr+1][gc] - img[gr-1][gc];
            a += gx * gx;
            b += gy * gy;
            c += gx * gy;
         end
      end
      det = a * b - c * c;
      tr  = a + b;
      return det - ((tr * tr * kk) >>> 8);
   endfunction

   function automatic int pixel_of(input int mode, input int x, input int y);
      case (mode)
         0: return 100;                                        // flat
         1: return (x >= 8) ? 220 : 20;                        // vertical step
         2: return (x >= 8 && y >= 6) ? 220 : 20;              // bright quadrant
         3: return int'($urandom % 256);                       // random
         default: return ($urandom % 2 == 0) ? 0 : 255;        // full swing
      endcase
   endfunction

   task automatic send_frame(input int mode, input bit gaps, input int rq);
      exp_t e;
      for (int y = 0; y < FH; y++)
         for (int x = 0; x < FW; x++)
            img[y][x] = pixel_of(mode, x, y);
      for (int y = 0; y < FH; y++) begin
         for (int x = 0; x < FW; x++) begin
            if (gaps && ($urandom % 3 == 0)) begin
               pix_valid = 1'b0;
               repeat (1 + $urandom % 3) @(negedge clk);
            end
            pix_valid = 1'b1;
            pix_data  = 8'(img[y][x]);
            pix_eol   = (x == FW - 1);
            e.sc  = model(x, y, kcur);
            e.eol = (x == FW - 1);
            e.rq  = (x < 4 || y < 4) ? 8'd5 : 8'(rq);
            q.push_back(e);
            if (in_cyc < 0) in_cyc = cyc;
            n_in++;
            @(negedge clk);
         end
      end
      pix_valid = 1'b0;
      pix_eol   = 1'b0;
   endtask

   task automatic drain();
      int guard = 0;
      while (q.size() != 0 && guard < 1000) begin
         @(negedge clk);
         guard++;
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic load_k(input int kk);
      k_value = 8'(kk);
      k_load  = 1'b1;
      @(negedge clk);
      k_load  = 1'b0;
      kcur    = kk;
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && score_valid) begin
         exp_t e;
         if (out_cyc < 0) out_cyc = cyc;
         n_out++;
         if (q.size() == 0) begin
            check(1'b0, 4, 1, 0);   // R4: score without a pixel
         end else begin
            e = q.pop_front();
            check(longint'(score) == longint'(e.sc), int'(e.rq), longint'(score), longint'(e.sc));
            check(score_eol == e.eol, 6, longint'(score_eol), longint'(e.eol)); // R6
         end
         out_img[oy][ox] = longint'(score);
         if (ox == FW - 1) begin
            ox = 0;
            oy = (oy == FH - 1) ? 0 : oy + 1;
         end else begin
            ox++;
         end
      end
   end

   initial begin
      repeat (40000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R7: idle outputs out of reset
      check(score_valid == 1'b0, 7, longint'(score_valid), 0);
      check(score_eol == 1'b0, 7, longint'(score_eol), 0);

      // R1 gradients and window sums on random data; uses reset k of 12 (R3)
      send_frame(3, 1'b0, 1);
      drain();
      // R7: sampled at edge n, seen in the half cycle after edge n+6
      check(out_cyc - in_cyc == 7, 7, out_cyc - in_cyc, 7);

      // R10 flat, edge and corner images
      send_frame(0, 1'b0, 10);
      drain();
      check(out_img[6][8] == 0, 10, out_img[6][8], 0);
      send_frame(1, 1'b0, 10);
      drain();
      check(out_img[8][9] < 0, 10, out_img[8][9], -1);
      send_frame(2, 1'b0, 10);
      drain();
      check(out_img[8][10] > 0, 10, out_img[8][10], 1);

      // R8 idle gaps between pixels
      send_frame(3, 1'b1, 8);
      drain();

      // R2 full-swing data with the largest k
      load_k(255);
      send_frame(4, 1'b0, 2);
      drain();

      // R3 loaded k value replaces the reset default
      load_k(40);
      send_frame(3, 1'b0, 3);
      drain();

      // R9 frames back to back, row counter wraps
      send_frame(3, 1'b0, 9);
      send_frame(4, 1'b1, 9);
      drain();
      repeat (20) @(negedge clk);

      // R4 one score per pixel, nothing left over
      check(n_out == n_in, 4, n_out, n_in);
      check(q.size() == 0, 4, q.size(), 0);

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule